// File: doc/BRIEF.md
# Kick-Committed Fractional Clock Enable

This block turns a free-running parent clock into a clock-enable stream of reduced average rate. Each frame is 32 parent cycles long. In every frame the block raises its enable output on exactly `m` of those cycles, so a consumer gated by the enable runs at the parent rate times `m/32`. Software does not store `m` directly. It stores a 5-bit reduction code, and the multiplier is 32 minus that code. A code of zero therefore means full rate.

A new rate takes effect in two steps. Software first writes the code into a shadow field of the rate word. It then sets a commit flag in a separate commit word. The block waits for the current frame to finish, moves the shadow code into the active register at that boundary, and clears the flag by itself. Software polls the flag and treats a set flag as busy. Inside a frame the enable pulses are spread evenly by a modulo-32 accumulator that adds the multiplier every cycle.

Top module: `frac_clk_gate`

## Requirements
- R1: After reset the active code and the shadow code are 0, the commit flag reads 0, and the enable output is high on every cycle once reset is released.
- R2: The rate word is at word address 1. Its bits 12:8 hold the shadow reduction code, which is written and read back there. All other bits of the rate word read as 0.
- R3: With active code `c`, the enable output is high on exactly `m = 32 - c` cycles of every 32 consecutive cycles. This holds for every code from 0 to 31.
- R4: The commit word is at word address 0, and its bit 31 is the commit flag. Writing 1 to bit 31 sets the flag, which then reads 1 while the commit is pending. A write with bit 31 at 0 changes nothing.
- R5: A set commit flag clears by itself at the end of the current 32-cycle frame, no more than 32 cycles after it was set. The new rate holds from the first cycle of the following frame.
- R6: A code written without a commit leaves the enable rate unchanged. Codes written while a commit is pending go to the shadow field, and the latest one written before the frame boundary is the code that gets committed.
- R7: The active code changes only at a frame boundary, so the first whole frame after a commit carries exactly the new multiplier. The accumulator is 0 at the start of every frame.
- R8: Setting the commit flag again while it is already set has no effect. The flag still clears at the boundary of the frame in which it was first set.
- R9: Within steady operation the spacing between consecutive enable pulses is always either floor(32/m) or ceil(32/m) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Word address: 0 is the commit word, 1 is the rate word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| clk_en_o | output | 1 | Fractional clock enable, registered |

## Verification
The bench builds the block with its default parameters: a 5-bit code and therefore a 32-cycle frame. At that size the bench can sweep the whole code space, so it checks every multiplier from 1 to 32 for pulse count. A subset of codes, including both ends, is also checked for pulse spacing and for the frame in which the rate changes. Because the frame is this short, the bench can also measure commit latency against its exact worst case of 32 cycles, and it can place writes so they land at known positions within a pending frame.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
    localparam int WORD_COMMIT = 0;
    localparam int WORD_RATE   = 1;
endpackage

// File: rtl/fcg_regs.sv
module fcg_regs #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 2,
    parameter int CODE_W   = 5,
    parameter int CODE_LSB = 8,
    parameter int KICK_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              commit_done,
    output logic [DATA_W-1:0] rdata,
    output logic [CODE_W-1:0] shadow_code,
    output logic              kick_pending
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              kick;
    } regs_t;

    regs_t r_d, r_q;
    logic  sel_commit, sel_rate;
    logic  unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        sel_commit = (addr == ADDR_W'(fcg_pkg::WORD_COMMIT));
        sel_rate   = (addr == ADDR_W'(fcg_pkg::WORD_RATE));
        r_d = r_q;
        if (wr_en && sel_rate)
            r_d.code = wdata[CODE_LSB +: CODE_W];
        if (wr_en && sel_commit && wdata[KICK_BIT])
            r_d.kick = 1'b1;
        if (commit_done)
            r_d.kick = 1'b0;
        rdata = '0;
        if (sel_commit)
            rdata[KICK_BIT] = r_q.kick;
        else if (sel_rate)
            rdata[CODE_LSB +: CODE_W] = r_q.code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign shadow_code  = r_q.code;
    assign kick_pending = r_q.kick;

    // R8: a pending flag stays set until the frame logic reports the commit
    assert_kick_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.kick && !commit_done) |=> r_q.kick);
    // R4: a write with the flag bit at zero never raises the flag
    assert_zero_write_inert_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.kick && wr_en && sel_commit && !wdata[KICK_BIT]) |=> !r_q.kick);
endmodule

// File: rtl/fcg_frame.sv
module fcg_frame #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick_pending,
    input  logic [CODE_W-1:0] shadow_code,
    output logic              commit_done,
    output logic              frame_start,
    output logic [CODE_W:0]   active_mult
);
    localparam int FRAME  = 1 << CODE_W;
    localparam int MULT_W = CODE_W + 1;

    typedef struct packed {
        logic [CODE_W-1:0] phase;
        logic [CODE_W-1:0] code;
    } frm_t;

    frm_t f_d, f_q;
    logic last;

    always_comb begin
        last        = (f_q.phase == {CODE_W{1'b1}});
        commit_done = kick_pending && last;
        f_d         = f_q;
        f_d.phase   = f_q.phase + CODE_W'(1);
        if (commit_done)
            f_d.code = shadow_code;
        frame_start = (f_q.phase == '0);
        active_mult = MULT_W'(FRAME) - MULT_W'(f_q.code);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    // R7: the active code holds through the middle of a frame
    assert_code_midframe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> $stable(f_q.code));
    // R6: without a pending commit the active code never moves
    assert_no_kick_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !kick_pending |=> $stable(f_q.code));
    // R5: a pending flag is served at the frame end and the code taken over
    assert_kick_served_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_pending && last) |=> (!kick_pending && f_q.code == $past(shadow_code)));
endmodule

// File: rtl/fcg_pattern.sv
module fcg_pattern #(
    parameter int CODE_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CODE_W:0] mult,
    input  logic            frame_start,
    output logic            en
);
    localparam int FRAME = 1 << CODE_W;
    localparam int SUM_W = CODE_W + 2;

    typedef struct packed {
        logic [CODE_W-1:0] acc;
        logic              en;
    } pat_t;

    pat_t p_d, p_q;
    logic [SUM_W-1:0] sum;
    logic             wrap;

    always_comb begin
        sum  = SUM_W'(p_q.acc) + SUM_W'(mult);
        wrap = (sum >= SUM_W'(FRAME));
        p_d.en  = wrap;
        p_d.acc = wrap ? CODE_W'(sum - SUM_W'(FRAME)) : CODE_W'(sum);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign en = p_q.en;

    // R7: every frame begins with an empty accumulator
    assert_acc_zero_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (p_q.acc == '0));
    // R3: full multiplier yields an enable on every cycle
    assert_full_rate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mult == (CODE_W+1)'(FRAME)) |=> en);
    // R3: multiplier of one never produces two pulses in a row
    assert_min_rate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mult == (CODE_W+1)'(1) && $past(mult) == (CODE_W+1)'(1) && en) |=> !en);
endmodule

// File: rtl/frac_clk_gate.sv
module frac_clk_gate #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 2,
    parameter int CODE_W   = 5,
    parameter int CODE_LSB = 8,
    parameter int KICK_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              clk_en_o
);
    logic [CODE_W-1:0] shadow_code;
    logic              kick_pending;
    logic              commit_done;
    logic              frame_start;
    logic [CODE_W:0]   active_mult;

    fcg_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W),
        .CODE_LSB(CODE_LSB), .KICK_BIT(KICK_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .commit_done(commit_done), .rdata(reg_rdata),
        .shadow_code(shadow_code), .kick_pending(kick_pending)
    );

    fcg_frame #(.CODE_W(CODE_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .kick_pending(kick_pending),
        .shadow_code(shadow_code), .commit_done(commit_done),
        .frame_start(frame_start), .active_mult(active_mult)
    );

    fcg_pattern #(.CODE_W(CODE_W)) u_pattern (
        .clk(clk), .rst_n(rst_n), .mult(active_mult),
        .frame_start(frame_start), .en(clk_en_o)
    );
endmodule

// File: tb/frac_clk_gate_bench.sv
module frac_clk_gate_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    localparam int VEC_CODE [NVEC] = '{0, 1, 7, 13, 16, 24, 30, 31};
    localparam int VEC_MULT [NVEC] = '{32, 31, 25, 19, 16, 8, 2, 1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        clk_en_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    frac_clk_gate u_frac_clk_gate (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_en_o(clk_en_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: run hung, cycles=%0d expected<150000", cycles);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_clear(output int lat);
        lat = 0;
        reg_addr = 2'd0;
        #1;
        while (reg_rdata[31] && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic measure(input int n, output int cnt, output int gmin, output int gmax);
        int prev;
        prev = -1; cnt = 0; gmin = 1000; gmax = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (clk_en_o) begin
                cnt++;
                if (prev >= 0) begin
                    if (i - prev < gmin) gmin = i - prev;
                    if (i - prev > gmax) gmax = i - prev;
                end
                prev = i;
            end
        end
    endtask

    task automatic commit_code(input int code, output int lat);
        wr(2'd1, 32'(code) << 8);
        wr(2'd0, 32'h8000_0000);
        wait_clear(lat);
    endtask

    initial begin
        logic [31:0] d;
        int lat, cnt, gmin, gmax, m;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(2'd0, d); check(d == 32'h0, "R1 commit word", int'(d), 0);
        rd(2'd1, d); check(d == 32'h0, "R1 rate word", int'(d), 0);
        measure(64, cnt, gmin, gmax);
        check(cnt == 64, "R1 full rate after reset", cnt, 64);

        // Table walk: R3 count, R5 latency, R7 first frame, R9 spacing
        for (int v = 0; v < NVEC; v++) begin
            m = VEC_MULT[v];
            commit_code(VEC_CODE[v], lat);
            check(lat <= 32, "R5 flag clear latency", lat, 32);
            measure(32, cnt, gmin, gmax);
            check(cnt == m, "R7 first frame after commit", cnt, m);
            measure(128, cnt, gmin, gmax);
            check(cnt == 4 * m, "R3 pulses in 4 frames", cnt, 4 * m);
            if (m > 1) begin
                check(gmin >= 32 / m, "R9 minimum gap", gmin, 32 / m);
                check(gmax <= (32 + m - 1) / m, "R9 maximum gap", gmax, (32 + m - 1) / m);
            end
        end

        // R3: every code
        for (int c = 0; c < 32; c++) begin
            commit_code(c, lat);
            @(negedge clk);
            measure(96, cnt, gmin, gmax);
            check(cnt == 3 * (32 - c), "R3 sweep count", cnt, 3 * (32 - c));
        end

        // R2: field placement and read-back
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, d); check(d == 32'h0000_1F00, "R2 rate word readback", int'(d), 32'h1F00);
        wr(2'd1, 32'h0000_0A00);
        rd(2'd1, d); check(d == 32'h0000_0A00, "R2 code 10 readback", int'(d), 32'h0A00);

        // R6: no commit, rate stays at code 31 (multiplier 1)
        measure(128, cnt, gmin, gmax);
        check(cnt == 4, "R6 uncommitted code ignored", cnt, 4);

        // R4: zero write leaves flag and rate alone
        wr(2'd0, 32'h7FFF_FFFF);
        rd(2'd0, d); check(d == 32'h0, "R4 zero flag write", int'(d), 0);
        measure(64, cnt, gmin, gmax);
        check(cnt == 2, "R4 rate unchanged after zero write", cnt, 2);

        // R4, R6: sync to a frame start, then kick and retarget while pending
        commit_code(31, lat);
        wr(2'd1, 32'd4 << 8);
        wr(2'd0, 32'h8000_0000);
        rd(2'd0, d); check(d == 32'h8000_0000, "R4 flag reads set", int'(d), 32'h8000_0000);
        wr(2'd1, 32'd20 << 8);
        rd(2'd1, d); check(d == (32'd20 << 8), "R6 shadow accepts pending write", int'(d), 20 << 8);
        wait_clear(lat);
        measure(128, cnt, gmin, gmax);
        check(cnt == 4 * 12, "R6 latest shadow committed", cnt, 48);

        // R8: second kick while pending does not delay the clear
        wr(2'd1, 32'd8 << 8);
        wr(2'd0, 32'h8000_0000);
        wr(2'd0, 32'h8000_0000);
        wait_clear(lat);
        check(lat + 1 <= 32, "R8 clear not delayed", lat + 1, 32);
        measure(128, cnt, gmin, gmax);
        check(cnt == 4 * 24, "R8 rate after double kick", cnt, 96);

        finish_run();
    end
endmodule